// File: doc/BRIEF.md
# Tempered Metropolis Accept/Reject Unit

This unit makes the accept/reject decision for a bank of tempered Markov chains. Chains are numbered j = 1..M. Each cycle it can take one candidate for one chain: the candidate's log-density, the candidate sample, and the natural log of a uniform random number computed elsewhere. The unit keeps the current log-density and current sample of every chain in an internal store. It reads the entry for the arriving chain in the same cycle.

The unit builds the chain's tempering factor from the chain index. Two multipliers then scale the candidate and the stored log-density in parallel. The scaled stored value is subtracted from the scaled candidate value, and the difference is compared with the random log value. The winner, either the candidate or the held state, is written back to the store and presented at the output together with an accept flag.

All arithmetic is fixed-point two's complement. The tempering factor uses 16 fractional bits. Candidates arrive in ascending chain order and wrap around after the last chain. Idle cycles are allowed between candidates.

Top module: `tempered_accept_unit`

## Requirements
- R1: After reset, out_valid is low and every chain's stored log-density and stored sample are zero.
- R2: The tempering factor used for input chain index k (chain j = k+1) is floor((CHAINS-k)^2 * 65536 / CHAINS^2). For k = 0 it is exactly 65536, which is 1.0.
- R3: Each log-density is scaled as floor(value * factor / 65536), with rounding toward minus infinity. The candidate and the stored value are scaled in the same cycle.
- R4: The log ratio is the scaled candidate log-density minus the scaled stored log-density, with no overflow for any input in range.
- R5: The candidate is accepted (out_accept = 1) only when the log ratio is strictly greater than in_log_u. A ratio equal to in_log_u is a rejection.
- R6: On acceptance, out_sample and out_logp carry the candidate sample and the unscaled candidate log-density.
- R7: On rejection, out_sample and out_logp carry the chain's stored sample and log-density. In both cases the store entry for that chain then holds the output values, and the chain's next candidate is judged against them.
- R8: A candidate presented with in_valid high is sampled at a rising edge. Its result appears three rising edges later, counting that edge, with out_valid high and out_chain equal to the presented in_chain.
- R9: A cycle with in_valid low changes no stored state and produces no output cycle with out_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A candidate is presented this cycle |
| in_chain | input | $clog2(CHAINS) | Zero-based chain index k; chain j = k+1 |
| in_cand_logp | input | LOGP_W | Candidate log-density, signed |
| in_cand_sample | input | SAMPLE_W | Candidate sample |
| in_log_u | input | LOGP_W | Log of a uniform random number, signed, same scale as log-densities |
| out_valid | output | 1 | A decision is presented this cycle |
| out_chain | output | $clog2(CHAINS) | Chain index of the decision |
| out_accept | output | 1 | 1 = candidate accepted, 0 = stored state kept |
| out_sample | output | SAMPLE_W | Sample chosen for the chain |
| out_logp | output | LOGP_W | Unscaled log-density chosen for the chain |

## Verification
The assertions assume three things about the inputs. Candidates arrive in chain order, so the same chain never returns within the three-cycle write-back window; this requires CHAINS of at least 3. in_chain stays below CHAINS. Log-density inputs keep enough headroom that a ratio plus or minus one still fits in_log_u. The stimulus walks the chains in strict ascending order with random idle gaps, and keeps every log-density within plus or minus 2^21. It places in_log_u either at the exact ratio computed by the bench, one step to either side of it, or at a random value inside that same bound.

// File: rtl/tmar_pkg.sv
package tmar_pkg;

    localparam int TF_FRAC = 16;
    localparam int TF_W    = TF_FRAC + 1;

    typedef enum logic {
        DEC_KEEP  = 1'b0,
        DEC_TAKE  = 1'b1
    } decision_e;

    // Tempering factor for zero-based index idx among m chains, Q1.16, floored.
    function automatic logic [TF_W-1:0] temper_q(input int idx, input int m);
        longint r;
        longint num;
        longint den;
        r   = longint'(m - idx);
        num = (r * r) <<< TF_FRAC;
        den = longint'(m) * longint'(m);
        return TF_W'(num / den);
    endfunction

endpackage

// File: rtl/tmar_temper_rom.sv
module tmar_temper_rom
    import tmar_pkg::*;
#(
    parameter int CHAINS = 8,
    localparam int CW    = $clog2(CHAINS)
) (
    input  logic [CW-1:0]   idx,
    output logic [TF_W-1:0] factor
);

    logic [TF_W-1:0] table_q [CHAINS];

    for (genvar g = 0; g < CHAINS; g++) begin : g_entry
        assign table_q[g] = temper_q(g, CHAINS);
    end

    assign factor = (int'(idx) < CHAINS) ? table_q[idx] : '0;

endmodule

// File: rtl/tmar_state_mem.sv
module tmar_state_mem #(
    parameter int CHAINS   = 8,
    parameter int LOGP_W   = 24,
    parameter int SAMPLE_W = 32,
    localparam int CW      = $clog2(CHAINS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CW-1:0]            rd_idx,
    output logic signed [LOGP_W-1:0] rd_logp,
    output logic [SAMPLE_W-1:0]      rd_sample,
    input  logic                     wr_en,
    input  logic [CW-1:0]            wr_idx,
    input  logic signed [LOGP_W-1:0] wr_logp,
    input  logic [SAMPLE_W-1:0]      wr_sample
);

    logic signed [LOGP_W-1:0] lg_q [CHAINS];
    logic [SAMPLE_W-1:0]      sm_q [CHAINS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CHAINS; i++) begin
                lg_q[i] <= '0;
                sm_q[i] <= '0;
            end
        end else if (wr_en) begin
            lg_q[wr_idx] <= wr_logp;
            sm_q[wr_idx] <= wr_sample;
        end
    end

    assign rd_logp   = lg_q[rd_idx];
    assign rd_sample = sm_q[rd_idx];

endmodule

// File: rtl/tmar_scale.sv
module tmar_scale
    import tmar_pkg::*;
#(
    parameter int LOGP_W = 24,
    localparam int PW    = LOGP_W + TF_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [LOGP_W-1:0] value,
    input  logic [TF_W-1:0]          factor,
    output logic signed [LOGP_W:0]   scaled
);

    logic signed [PW-1:0] prod;

    assign prod = value * $signed({1'b0, factor});

    always_ff @(posedge clk) begin
        if (rst) scaled <= '0;
        else     scaled <= (LOGP_W+1)'(prod >>> TF_FRAC);
    end

    // A factor of at most 1.0 can never enlarge a magnitude.
    logic signed [LOGP_W+1:0] mag_in;
    logic signed [LOGP_W+1:0] mag_out;
    assign mag_in  = (value  < 0) ? -(LOGP_W+2)'(value)  : (LOGP_W+2)'(value);
    assign mag_out = (scaled < 0) ? -(LOGP_W+2)'(scaled) : (LOGP_W+2)'(scaled);

    a_r3_no_growth: assert property (@(posedge clk) disable iff (rst)
        mag_out <= $past(mag_in));

endmodule

// File: rtl/tempered_accept_unit.sv
module tempered_accept_unit
    import tmar_pkg::*;
#(
    parameter int CHAINS   = 8,
    parameter int LOGP_W   = 24,
    parameter int SAMPLE_W = 32,
    localparam int CW      = $clog2(CHAINS),
    localparam int DW      = LOGP_W + 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [CW-1:0]            in_chain,
    input  logic signed [LOGP_W-1:0] in_cand_logp,
    input  logic [SAMPLE_W-1:0]      in_cand_sample,
    input  logic signed [LOGP_W-1:0] in_log_u,
    output logic                     out_valid,
    output logic [CW-1:0]            out_chain,
    output logic                     out_accept,
    output logic [SAMPLE_W-1:0]      out_sample,
    output logic signed [LOGP_W-1:0] out_logp
);

    typedef struct packed {
        logic [CW-1:0]            chain;
        logic [SAMPLE_W-1:0]      cand_s;
        logic [SAMPLE_W-1:0]      prev_s;
        logic signed [LOGP_W-1:0] cand_l;
        logic signed [LOGP_W-1:0] prev_l;
        logic signed [LOGP_W-1:0] log_u;
    } ctx_t;

    // ---------------- stage 0: factor lookup and state read ----------------
    logic [TF_W-1:0]          factor;
    logic signed [LOGP_W-1:0] rd_logp;
    logic [SAMPLE_W-1:0]      rd_sample;
    logic                     wr_en;
    logic signed [LOGP_W-1:0] wr_logp;
    logic [SAMPLE_W-1:0]      wr_sample;
    logic [CW-1:0]            wr_idx;

    tmar_temper_rom #(.CHAINS(CHAINS)) u_rom (
        .idx    (in_chain),
        .factor (factor)
    );

    tmar_state_mem #(
        .CHAINS   (CHAINS),
        .LOGP_W   (LOGP_W),
        .SAMPLE_W (SAMPLE_W)
    ) u_mem (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (in_chain),
        .rd_logp   (rd_logp),
        .rd_sample (rd_sample),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_logp   (wr_logp),
        .wr_sample (wr_sample)
    );

    // ---------------- stage 1: two parallel multipliers ----------------
    logic signed [LOGP_W-1:0] sc_in  [2];
    logic signed [LOGP_W:0]   sc_out [2];

    assign sc_in[0] = in_cand_logp;
    assign sc_in[1] = rd_logp;

    for (genvar g = 0; g < 2; g++) begin : g_scale
        tmar_scale #(.LOGP_W(LOGP_W)) u_scale (
            .clk    (clk),
            .rst    (rst),
            .value  (sc_in[g]),
            .factor (factor),
            .scaled (sc_out[g])
        );
    end

    logic s1_valid;
    ctx_t s1_ctx;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_ctx   <= '0;
        end else begin
            s1_valid      <= in_valid;
            s1_ctx.chain  <= in_chain;
            s1_ctx.cand_s <= in_cand_sample;
            s1_ctx.prev_s <= rd_sample;
            s1_ctx.cand_l <= in_cand_logp;
            s1_ctx.prev_l <= rd_logp;
            s1_ctx.log_u  <= in_log_u;
        end
    end

    // ---------------- stage 2: subtract ----------------
    logic                 s2_valid;
    ctx_t                 s2_ctx;
    logic signed [DW-1:0] s2_ratio;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
            s2_ctx   <= '0;
            s2_ratio <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_ctx   <= s1_ctx;
            s2_ratio <= DW'(sc_out[0]) - DW'(sc_out[1]);
        end
    end

    // ---------------- stage 3: compare, select, write back ----------------
    decision_e            dec;
    logic signed [DW-1:0] u_ext;

    assign u_ext = DW'(s2_ctx.log_u);
    assign dec   = (s2_ratio > u_ext) ? DEC_TAKE : DEC_KEEP;

    assign wr_en     = s2_valid;
    assign wr_idx    = s2_ctx.chain;
    assign wr_logp   = (dec == DEC_TAKE) ? s2_ctx.cand_l : s2_ctx.prev_l;
    assign wr_sample = (dec == DEC_TAKE) ? s2_ctx.cand_s : s2_ctx.prev_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_chain  <= '0;
            out_accept <= 1'b0;
            out_sample <= '0;
            out_logp   <= '0;
        end else begin
            out_valid  <= s2_valid;
            out_chain  <= s2_ctx.chain;
            out_accept <= (dec == DEC_TAKE);
            out_sample <= wr_sample;
            out_logp   <= wr_logp;
        end
    end

    // ---------------- checks ----------------
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)              age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);

    a_r8_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    a_r8_chain_follows: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_chain == $past(in_chain, 3)));

    a_r6_take_candidate: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_accept) |->
            (out_sample == $past(in_cand_sample, 3) && out_logp == $past(in_cand_logp, 3)));

endmodule

// File: tb/tempered_accept_unit_bench.sv
module tempered_accept_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int M  = 8;
    localparam int LW = 24;
    localparam int SW = 32;
    localparam int CW = $clog2(M);
    localparam longint SPAN = 64'sd1 <<< 21;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 in_valid;
    logic [CW-1:0]        in_chain;
    logic signed [LW-1:0] in_cand_logp;
    logic [SW-1:0]        in_cand_sample;
    logic signed [LW-1:0] in_log_u;
    logic                 out_valid;
    logic [CW-1:0]        out_chain;
    logic                 out_accept;
    logic [SW-1:0]        out_sample;
    logic signed [LW-1:0] out_logp;

    tempered_accept_unit #(
        .CHAINS   (M),
        .LOGP_W   (LW),
        .SAMPLE_W (SW)
    ) u_tempered_accept_unit (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (in_valid),
        .in_chain       (in_chain),
        .in_cand_logp   (in_cand_logp),
        .in_cand_sample (in_cand_sample),
        .in_log_u       (in_log_u),
        .out_valid      (out_valid),
        .out_chain      (out_chain),
        .out_accept     (out_accept),
        .out_sample     (out_sample),
        .out_logp       (out_logp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        int          chain;
        bit          acc;
        bit          first;
        logic [SW-1:0] s;
        longint      l;
    } exp_t;

    exp_t   q[$];
    longint mdl_l [M];
    logic [SW-1:0] mdl_s [M];
    bit     seen [M];
    int     n_vec = 0;
    int     n_bad = 0;

    // R2: expected factor, floored Q1.16
    function automatic longint tfq(int idx);
        longint r = longint'(M - idx);
        return ((r * r) <<< 16) / (longint'(M) * longint'(M));
    endfunction

    // R3: floor scaling
    function automatic longint scl(longint x, longint t);
        return (x * t) >>> 16;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exv, cyc);
        end
    endtask

    task automatic observe();
        if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e = q.pop_front();
            chk(out_valid == 1'b1, "R8 valid latency", longint'(out_valid), 1);
            chk(int'(out_chain) == e.chain, "R8 chain", longint'(out_chain), e.chain);
            chk(out_accept == e.acc, "R2 R3 R4 R5 decision", longint'(out_accept), e.acc);
            if (e.acc) begin
                chk(out_sample == e.s, "R6 sample", longint'(out_sample), longint'(e.s));
                chk(longint'(out_logp) == e.l, "R6 logp", longint'(out_logp), e.l);
            end else begin
                chk(out_sample == e.s, e.first ? "R1 R7 sample kept" : "R7 sample kept",
                    longint'(out_sample), longint'(e.s));
                chk(longint'(out_logp) == e.l, e.first ? "R1 R7 logp kept" : "R7 logp kept",
                    longint'(out_logp), e.l);
            end
        end else begin
            chk(out_valid == 1'b0, "R9 no output", longint'(out_valid), 0);
        end
    endtask

    // mode 0: log_u equals ratio (reject), 1: ratio-1 (accept), 2: ratio+1, 3: random
    task automatic issue(int idx, longint cand, int mode);
        longint t, ratio, lu;
        logic [SW-1:0] smp;
        bit acc;
        exp_t e;
        t     = tfq(idx);
        ratio = scl(cand, t) - scl(mdl_l[idx], t);
        case (mode)
            0:       lu = ratio;
            1:       lu = ratio - 1;
            2:       lu = ratio + 1;
            default: lu = longint'($urandom_range(0, 32'(2 * SPAN))) - SPAN;
        endcase
        smp = $urandom;
        acc = ratio > lu;
        in_valid       = 1'b1;
        in_chain       = CW'(idx);
        in_cand_logp   = cand[LW-1:0];
        in_cand_sample = smp;
        in_log_u       = lu[LW-1:0];
        e.due   = cyc + 3;
        e.chain = idx;
        e.acc   = acc;
        e.first = !seen[idx];
        if (acc) begin
            mdl_l[idx] = cand;
            mdl_s[idx] = smp;
        end
        e.s = mdl_s[idx];
        e.l = mdl_l[idx];
        seen[idx] = 1'b1;
        q.push_back(e);
    endtask

    function automatic longint pick_cand();
        int r = $urandom_range(0, 9);
        if (r == 0) return SPAN;
        if (r == 1) return -SPAN;
        if (r == 2) return 0;
        return longint'($urandom_range(0, 32'(2 * SPAN))) - SPAN;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < M; i++) begin
            mdl_l[i] = 0;
            mdl_s[i] = '0;
            seen[i]  = 1'b0;
        end
        rst = 1'b1;
        in_valid = 1'b0;
        in_chain = '0;
        in_cand_logp = '0;
        in_cand_sample = '0;
        in_log_u = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(out_valid == 1'b0, "R1 reset valid", longint'(out_valid), 0);

        for (int p = 0; p < 40; p++) begin
            for (int idx = 0; idx < M; idx++) begin
                int mode;
                if ($urandom_range(0, 4) == 0) begin
                    @(negedge clk);
                    observe();
                    in_valid = 1'b0;
                end
                @(negedge clk);
                observe();
                if (p == 0 && idx == 0)      mode = 1; // R2 unit factor, accept by one step
                else if (p == 1 && idx == 0) mode = 0; // R5 tie rejects
                else if (p == 1 && idx == M-1) mode = 0; // R5 tie on smallest factor
                else                         mode = $urandom_range(0, 3);
                issue(idx, pick_cand(), mode);
            end
        end
        repeat (6) begin
            @(negedge clk);
            observe();
            in_valid = 1'b0;
        end
        chk(q.size() == 0, "R8 all results seen", q.size(), 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule